// File: doc/BRIEF.md
# PHY Extended Register Access Sequencer

This block sits between a register client and a single-transaction management-bus master. The client hands over one request at a time: a PHY address, a 16-bit register number, a read/write flag and write data. The sequencer turns that request into the basic management transactions the PHY needs. Register numbers 0x0000 to 0x001F are reached with one plain transaction. Any higher register number is reached through a fixed indirect series of four transactions. That series uses the indirect control register and the indirect address/data register.

The master below is driven through a start/busy/done handshake. The block raises a one-cycle start with the register, direction and data of the current step. It then waits for the master's done pulse before it issues the next step. When the last step completes, the block raises a one-cycle done strobe. For a read, it also presents the data returned by the last step. It keeps that data unchanged until the next request is accepted.

Top module: `phy_xreg_seq`

## Requirements
- R1: A request whose register number is 0x001F or lower produces exactly one transaction. That transaction carries the low five bits of the register number, the request's read/write flag and its write data.
- R2: A request whose register number is above 0x001F produces exactly four transactions in this order. First, a write of 0x001F to register 0x0D. Second, a write of the register number to register 0x0E. Third, a write of 0x401F to register 0x0D. Fourth, a read or write of register 0x0E that uses the request's flag and write data.
- R3: A step is started with a single-cycle `mgmt_start`. `mgmt_start` is never high while `mgmt_busy` is high. The next step is not started until `mgmt_done` has been seen for the current one.
- R4: Every transaction of a request carries the PHY address captured in the cycle the request was accepted.
- R5: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A request presented while a sequence is running has no effect on that sequence.
- R6: `rsp_done` is high for exactly one cycle. That cycle is the one after the cycle in which `mgmt_done` completes the last step.
- R7: For a read, `rsp_rdata` takes the `mgmt_rdata` of the last step and is held until the next request is accepted. A write request leaves `rsp_rdata` unchanged.
- R8: A `mgmt_done` pulse that arrives while no step is outstanding is ignored. It produces no `rsp_done` and no change of `rsp_rdata`.
- R9: After reset, `req_ready` is 1 and `rsp_done`, `mgmt_start` and `rsp_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_phy | input | PHY_AW | Target PHY address |
| req_reg | input | REG_NUM_W | Target register number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DW | Read result, held |
| mgmt_start | output | 1 | Start one management transaction |
| mgmt_busy | input | 1 | Master is busy |
| mgmt_done | input | 1 | Master finished a transaction |
| mgmt_phy | output | PHY_AW | PHY address of the transaction |
| mgmt_reg | output | 5 | Direct register address of the transaction |
| mgmt_write | output | 1 | Transaction direction, 1 = write |
| mgmt_wdata | output | DW | Transaction write data |
| mgmt_rdata | input | DW | Data returned with `mgmt_done` |

## Verification
Two events can fall in the same cycle. One is the completion of a sequence's last step. The other is the arrival of the next request, which can be kept asserted across that completion. The bench holds a second request on `req_valid` during a running indirect read. It then judges three results: the running sequence still issues exactly four transactions, the read data is returned first, and the held request is taken only once the sequencer is idle again. A stray `mgmt_done` pulse while idle is also injected, and `rsp_done` and `rsp_rdata` are checked for no reaction.

// File: rtl/phy_xreg_pkg.sv
// Package: shared constants and enumerations for the extended register
// access sequencer. Assumes a five-bit direct register space.
package phy_xreg_pkg;

    localparam int unsigned DIR_AW = 5;
    localparam logic [DIR_AW-1:0] XCTL_ADDR  = 5'h0D;  // indirect control register
    localparam logic [DIR_AW-1:0] XDATA_ADDR = 5'h0E;  // indirect address/data register
    localparam logic [15:0] XCTL_SEL_ADDR  = 16'h001F; // select address mode
    localparam logic [15:0] XCTL_SEL_DATA  = 16'h401F; // data mode, no increment

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        STEP_SEL  = 2'd0,
        STEP_ADDR = 2'd1,
        STEP_MODE = 2'd2,
        STEP_DATA = 2'd3
    } seq_step_t;

endpackage

// File: rtl/phy_xreg_req_latch.sv
// Request latch: holds the accepted request for the whole sequence and
// classifies it as direct or indirect. Assumes accept is a one-cycle pulse.
module phy_xreg_req_latch
    import phy_xreg_pkg::*;
#(
    parameter int unsigned PHY_AW    = 5,
    parameter int unsigned REG_NUM_W = 16,
    parameter int unsigned DW        = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [PHY_AW-1:0]    in_phy,
    input  logic [REG_NUM_W-1:0] in_reg,
    input  logic                 in_write,
    input  logic [DW-1:0]        in_wdata,
    output logic                 in_is_ext,
    output logic [PHY_AW-1:0]    cap_phy,
    output logic [REG_NUM_W-1:0] cap_reg,
    output logic                 cap_write,
    output logic [DW-1:0]        cap_wdata,
    output logic                 cap_is_ext
);

    // Classify the presented register number: any bit above the direct range set.
    always_comb begin
        in_is_ext = |in_reg[REG_NUM_W-1:DIR_AW];
    end

    // Capture the request fields when the request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_phy    <= '0;
            cap_reg    <= '0;
            cap_write  <= 1'b0;
            cap_wdata  <= '0;
            cap_is_ext <= 1'b0;
        end else if (accept) begin
            cap_phy    <= in_phy;
            cap_reg    <= in_reg;
            cap_write  <= in_write;
            cap_wdata  <= in_wdata;
            cap_is_ext <= in_is_ext;
        end
    end

endmodule

// File: rtl/phy_xreg_step_fsm.sv
// Step controller: walks the steps of a sequence, issues one start per
// step when the master is free, waits for its done, and raises the
// completion strobe. Direct requests begin at the final data step.
module phy_xreg_step_fsm
    import phy_xreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      in_is_ext,
    input  logic      mgmt_busy,
    input  logic      mgmt_done,
    output logic      ready,
    output logic      accept,
    output seq_step_t step,
    output logic      start,
    output logic      last_fire,
    output logic      done_pulse
);

    seq_state_t state;

    // Handshake decode from the current state.
    always_comb begin
        ready     = (state == SEQ_IDLE);
        accept    = ready && req_valid;
        start     = (state == SEQ_ISSUE) && !mgmt_busy;
        last_fire = (state == SEQ_WAIT) && mgmt_done && (step == STEP_DATA);
    end

    // Sequence state, step index and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            step       <= STEP_DATA;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        state <= SEQ_ISSUE;
                        step  <= in_is_ext ? STEP_SEL : STEP_DATA;
                    end
                end
                SEQ_ISSUE: begin
                    if (!mgmt_busy) begin
                        state <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (mgmt_done) begin
                        if (step == STEP_DATA) begin
                            state      <= SEQ_IDLE;
                            done_pulse <= 1'b1;
                        end else begin
                            step  <= seq_step_t'(step + 2'd1);
                            state <= SEQ_ISSUE;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/phy_xreg_cmd_mux.sv
// Command selector: forms the register address, direction and data of the
// current step from the captured request. Purely combinational.
module phy_xreg_cmd_mux
    import phy_xreg_pkg::*;
#(
    parameter int unsigned REG_NUM_W = 16,
    parameter int unsigned DW        = 16
) (
    input  seq_step_t            step,
    input  logic                 cap_is_ext,
    input  logic [REG_NUM_W-1:0] cap_reg,
    input  logic                 cap_write,
    input  logic [DW-1:0]        cap_wdata,
    output logic [DIR_AW-1:0]    cmd_reg,
    output logic                 cmd_write,
    output logic [DW-1:0]        cmd_wdata
);

    localparam logic [DW-1:0] WORD_SEL_ADDR = DW'(XCTL_SEL_ADDR);
    localparam logic [DW-1:0] WORD_SEL_DATA = DW'(XCTL_SEL_DATA);

    // Select the fields of the step being issued.
    always_comb begin
        cmd_reg   = XCTL_ADDR;
        cmd_write = 1'b1;
        cmd_wdata = WORD_SEL_ADDR;
        case (step)
            STEP_SEL: begin
                cmd_reg   = XCTL_ADDR;
                cmd_wdata = WORD_SEL_ADDR;
            end
            STEP_ADDR: begin
                cmd_reg   = XDATA_ADDR;
                cmd_wdata = DW'(cap_reg);
            end
            STEP_MODE: begin
                cmd_reg   = XCTL_ADDR;
                cmd_wdata = WORD_SEL_DATA;
            end
            default: begin
                cmd_reg   = cap_is_ext ? XDATA_ADDR : cap_reg[DIR_AW-1:0];
                cmd_write = cap_write;
                cmd_wdata = cap_wdata;
            end
        endcase
    end

endmodule

// File: rtl/phy_xreg_rd_hold.sv
// Read result register: loads the last step's read data and keeps it until
// the next load. Assumes capture is high for one cycle per read completion.
module phy_xreg_rd_hold #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    // Hold the most recent read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (capture) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/phy_xreg_seq.sv
// Top: turns one register request into direct or indirect management
// transactions. Assumes a master with a start/busy/done handshake that
// returns read data together with done.
module phy_xreg_seq
    import phy_xreg_pkg::*;
#(
    parameter int unsigned PHY_AW    = 5,
    parameter int unsigned REG_NUM_W = 16,
    parameter int unsigned DW        = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [PHY_AW-1:0]    req_phy,
    input  logic [REG_NUM_W-1:0] req_reg,
    input  logic                 req_write,
    input  logic [DW-1:0]        req_wdata,
    output logic                 rsp_done,
    output logic [DW-1:0]        rsp_rdata,
    output logic                 mgmt_start,
    input  logic                 mgmt_busy,
    input  logic                 mgmt_done,
    output logic [PHY_AW-1:0]    mgmt_phy,
    output logic [DIR_AW-1:0]    mgmt_reg,
    output logic                 mgmt_write,
    output logic [DW-1:0]        mgmt_wdata,
    input  logic [DW-1:0]        mgmt_rdata
);

    logic                 accept;
    logic                 in_is_ext;
    logic                 last_fire;
    seq_step_t            step;
    logic [REG_NUM_W-1:0] cap_reg;
    logic                 cap_write;
    logic [DW-1:0]        cap_wdata;
    logic                 cap_is_ext;
    logic                 rd_capture;

    phy_xreg_req_latch #(
        .PHY_AW(PHY_AW), .REG_NUM_W(REG_NUM_W), .DW(DW)
    ) i_latch (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .in_phy(req_phy), .in_reg(req_reg), .in_write(req_write), .in_wdata(req_wdata),
        .in_is_ext(in_is_ext),
        .cap_phy(mgmt_phy), .cap_reg(cap_reg), .cap_write(cap_write),
        .cap_wdata(cap_wdata), .cap_is_ext(cap_is_ext)
    );

    phy_xreg_step_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .in_is_ext(in_is_ext),
        .mgmt_busy(mgmt_busy), .mgmt_done(mgmt_done),
        .ready(req_ready), .accept(accept), .step(step), .start(mgmt_start),
        .last_fire(last_fire), .done_pulse(rsp_done)
    );

    phy_xreg_cmd_mux #(
        .REG_NUM_W(REG_NUM_W), .DW(DW)
    ) i_mux (
        .step(step), .cap_is_ext(cap_is_ext), .cap_reg(cap_reg),
        .cap_write(cap_write), .cap_wdata(cap_wdata),
        .cmd_reg(mgmt_reg), .cmd_write(mgmt_write), .cmd_wdata(mgmt_wdata)
    );

    // Load read data only when a read request completes.
    always_comb begin
        rd_capture = last_fire && !cap_write;
    end

    phy_xreg_rd_hold #(
        .DW(DW)
    ) i_rd (
        .clk(clk), .rst_n(rst_n), .capture(rd_capture),
        .din(mgmt_rdata), .dout(rsp_rdata)
    );

endmodule

// File: rtl/phy_xreg_chk.sv
// Checker: protocol properties of the sequencer, bound to the top module.
module phy_xreg_chk #(
    parameter int unsigned PHY_AW = 5,
    parameter int unsigned DW     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [DW-1:0]     rsp_rdata,
    input logic              mgmt_start,
    input logic              mgmt_busy,
    input logic [PHY_AW-1:0] mgmt_phy,
    input logic [4:0]        mgmt_reg,
    input logic              mgmt_write,
    input logic [DW-1:0]     mgmt_wdata
);

    AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_start |-> !mgmt_busy); // R3
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_start |=> !mgmt_start); // R3
    AST_CTL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_start && mgmt_reg == 5'h0D) |->
        (mgmt_write && (mgmt_wdata == DW'(16'h001F) || mgmt_wdata == DW'(16'h401F)))); // R2
    AST_PHY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(mgmt_phy)); // R4
    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> $stable(rsp_rdata)); // R7

endmodule

bind phy_xreg_seq phy_xreg_chk #(.PHY_AW(PHY_AW), .DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mgmt_start(mgmt_start),
    .mgmt_busy(mgmt_busy), .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg),
    .mgmt_write(mgmt_write), .mgmt_wdata(mgmt_wdata)
);

// File: tb/test_phy_xreg_seq.sv
module test_phy_xreg_seq;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int NVEC       = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_phy = '0;
    logic [15:0] req_reg = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        mgmt_start;
    logic        mgmt_busy;
    logic        mgmt_done;
    logic [4:0]  mgmt_phy;
    logic [4:0]  mgmt_reg;
    logic        mgmt_write;
    logic [15:0] mgmt_wdata;
    logic [15:0] mgmt_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_xreg_seq i_phy_xreg_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_phy(req_phy), .req_reg(req_reg), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mgmt_start(mgmt_start),
        .mgmt_busy(mgmt_busy), .mgmt_done(mgmt_done), .mgmt_phy(mgmt_phy),
        .mgmt_reg(mgmt_reg), .mgmt_write(mgmt_write), .mgmt_wdata(mgmt_wdata),
        .mgmt_rdata(mgmt_rdata)
    );

    // ---- management master + PHY model with its own indirect decode ----
    logic        m_active = 1'b0;
    int          m_cnt = 0;
    logic [4:0]  m_reg, m_phy;
    logic        m_wr;
    logic [15:0] m_wd;
    logic        m_done = 1'b0;
    logic [15:0] m_rd = '0;
    logic        stall = 1'b0;
    logic        inj_done = 1'b0;
    logic [15:0] dir_regs [32];
    logic [15:0] ext_regs [256];
    logic [15:0] xctl = '0;
    logic [15:0] xaddr = '0;
    int          txn_total = 0;
    logic [4:0]  log_reg  [256];
    logic        log_wr   [256];
    logic [15:0] log_data [256];
    logic [4:0]  log_phy  [256];

    assign mgmt_busy  = m_active | stall;
    assign mgmt_done  = m_done | inj_done;
    assign mgmt_rdata = inj_done ? 16'hFFFF : m_rd;

    initial begin
        for (int i = 0; i < 32; i++) dir_regs[i] = '0;
        for (int i = 0; i < 256; i++) ext_regs[i] = '0;
    end

    always @(posedge clk) begin
        m_done <= 1'b0;
        if (!rst_n) begin
            m_active <= 1'b0;
            m_cnt    <= 0;
        end else if (m_active) begin
            if (m_cnt == LAT) begin
                m_active <= 1'b0;
                m_done   <= 1'b1;
                log_reg[txn_total[7:0]]  <= m_reg;
                log_wr[txn_total[7:0]]   <= m_wr;
                log_data[txn_total[7:0]] <= m_wd;
                log_phy[txn_total[7:0]]  <= m_phy;
                txn_total <= txn_total + 1;
                if (m_reg == 5'h0E && xctl == 16'h401F) begin
                    m_rd <= ext_regs[xaddr[7:0]];
                    if (m_wr) ext_regs[xaddr[7:0]] <= m_wd;
                end else if (m_reg == 5'h0E) begin
                    m_rd <= xaddr;
                    if (m_wr) xaddr <= m_wd;
                end else if (m_reg == 5'h0D) begin
                    m_rd <= xctl;
                    if (m_wr) xctl <= m_wd;
                end else begin
                    m_rd <= dir_regs[m_reg];
                    if (m_wr) dir_regs[m_reg] <= m_wd;
                end
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end else if (mgmt_start && !stall) begin
            m_active <= 1'b1;
            m_cnt    <= 0;
            m_reg    <= mgmt_reg;
            m_phy    <= mgmt_phy;
            m_wr     <= mgmt_write;
            m_wd     <= mgmt_wdata;
        end
    end

    // ---- bookkeeping ----
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Fields: phy(5) reg(16) write(1) wdata(16) expected rdata(16) transactions(3)
    localparam logic [56:0] VECS [NVEC] = '{
        {5'd1,  16'h0031, 1'b1, 16'h0061, 16'h0000, 3'd4},
        {5'd1,  16'h0031, 1'b0, 16'h0000, 16'h0061, 3'd4},
        {5'd3,  16'h0004, 1'b1, 16'h01E1, 16'h0000, 3'd1},
        {5'd3,  16'h0004, 1'b0, 16'h0000, 16'h01E1, 3'd1},
        {5'd12, 16'h001F, 1'b1, 16'hBEEF, 16'h0000, 3'd1},
        {5'd12, 16'h0020, 1'b1, 16'h1234, 16'h0000, 3'd4},
        {5'd12, 16'h001F, 1'b0, 16'h0000, 16'hBEEF, 3'd1},
        {5'd15, 16'h0020, 1'b0, 16'h0000, 16'h1234, 3'd4},
        {5'd1,  16'h00D3, 1'b0, 16'h0000, 16'h0000, 3'd4}
    };

    // Present a request at a negedge until it is accepted.
    task automatic send(input logic [4:0] p, input logic [15:0] r, input logic w, input logic [15:0] d);
        @(negedge clk);
        req_phy = p; req_reg = r; req_write = w; req_wdata = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Wait for rsp_done; count transactions; check the done timing (R6).
    task automatic wait_done(input int base, output int ntx);
        int guard = 0;
        bit prev_done = 1'b0;
        while (!rsp_done && guard < 200) begin
            prev_done = mgmt_done;
            @(negedge clk);
            guard++;
        end
        check(rsp_done == 1'b1, "R6 done seen", rsp_done, 1);
        check(prev_done == 1'b1, "R6 done follows last mgmt_done", prev_done, 1);
        ntx = txn_total - base;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base, ntx;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(req_ready == 1'b1, "R9 ready", req_ready, 1);
        check(rsp_done == 1'b0, "R9 done", rsp_done, 0);
        check(mgmt_start == 1'b0, "R9 start", mgmt_start, 0);
        check(rsp_rdata == 16'h0, "R9 rdata", rsp_rdata, 0);
        rst_n = 1'b1;

        // Vector table (R1, R2, R4, R7)
        for (int v = 0; v < NVEC; v++) begin
            logic [56:0] e;
            e = VECS[v];
            base = txn_total;
            held = rsp_rdata;
            send(e[56:52], e[51:36], e[35], e[34:19]);
            wait_done(base, ntx);
            check(ntx == int'(e[2:0]), e[51:36] > 16'h1F ? "R2 txn count" : "R1 txn count", ntx, e[2:0]);
            if (!e[35])
                check(rsp_rdata == e[18:3], "R7 read data", rsp_rdata, e[18:3]);
            else
                check(rsp_rdata == held, "R7 write keeps rdata", rsp_rdata, held);
            for (int k = 0; k < ntx; k++)
                check(log_phy[base + k] == e[56:52], "R4 phy per step", log_phy[base + k], e[56:52]);
            @(negedge clk);
            check(rsp_done == 1'b0, "R6 single cycle", rsp_done, 0);
        end

        // R2 exact step order for an indirect write
        base = txn_total;
        send(5'd3, 16'h0086, 1'b1, 16'h00A5);
        wait_done(base, ntx);
        check(log_reg[base] == 5'h0D && log_wr[base] && log_data[base] == 16'h001F, "R2 step1", log_data[base], 16'h001F);
        check(log_reg[base+1] == 5'h0E && log_wr[base+1] && log_data[base+1] == 16'h0086, "R2 step2", log_data[base+1], 16'h0086);
        check(log_reg[base+2] == 5'h0D && log_wr[base+2] && log_data[base+2] == 16'h401F, "R2 step3", log_data[base+2], 16'h401F);
        check(log_reg[base+3] == 5'h0E && log_wr[base+3] && log_data[base+3] == 16'h00A5, "R2 step4", log_data[base+3], 16'h00A5);
        check(ext_regs[8'h86] == 16'h00A5, "R2 target written", ext_regs[8'h86], 16'h00A5);

        // R1 direct write of register 0x001F carries low five bits
        base = txn_total;
        send(5'd1, 16'h001F, 1'b1, 16'h5A5A);
        wait_done(base, ntx);
        check(log_reg[base] == 5'h1F && log_data[base] == 16'h5A5A, "R1 direct fields", log_reg[base], 5'h1F);

        // R3 start withheld while master busy
        stall = 1'b1;
        base = txn_total;
        send(5'd1, 16'h0004, 1'b0, 16'h0);
        for (int k = 0; k < 5; k++) begin
            check(mgmt_start == 1'b0, "R3 no start while busy", mgmt_start, 0);
            @(negedge clk);
        end
        stall = 1'b0;
        @(negedge clk);
        check(mgmt_start == 1'b0 || !mgmt_busy, "R3 start after release", mgmt_start, 1);
        wait_done(base, ntx);
        check(ntx == 1, "R3 one txn", ntx, 1);

        // R5: request held across a running indirect read, taken only after done
        base = txn_total;
        @(negedge clk);
        req_phy = 5'd1; req_reg = 16'h0031; req_write = 1'b0; req_wdata = '0; req_valid = 1'b1;
        @(negedge clk);
        req_phy = 5'd15; req_reg = 16'h0004; req_write = 1'b1; req_wdata = 16'hDEAD;
        check(req_ready == 1'b0, "R5 not ready while running", req_ready, 0);
        wait_done(base, ntx);
        check(ntx == 4, "R5 running sequence unchanged", ntx, 4);
        check(rsp_rdata == 16'h0061, "R5 read returned first", rsp_rdata, 16'h0061);
        held = rsp_rdata;
        base = txn_total;
        @(negedge clk);
        check(req_ready == 1'b0, "R5 held request taken when idle", req_ready, 0);
        req_valid = 1'b0;
        wait_done(base, ntx);
        check(ntx == 1 && dir_regs[4] == 16'hDEAD, "R5 held write done once", ntx, 1);
        check(rsp_rdata == held, "R7 write leaves rdata", rsp_rdata, held);

        // R7 hold over idle cycles
        repeat (6) @(negedge clk);
        check(rsp_rdata == held, "R7 held while idle", rsp_rdata, held);

        // R8 stray done while idle
        inj_done = 1'b1;
        @(negedge clk);
        inj_done = 1'b0;
        check(rsp_done == 1'b0, "R8 no done from stray", rsp_done, 0);
        @(negedge clk);
        check(rsp_done == 1'b0, "R8 no done later", rsp_done, 0);
        check(rsp_rdata == held, "R8 rdata unchanged", rsp_rdata, held);
        check(req_ready == 1'b1, "R8 still idle", req_ready, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule